// File: doc/BRIEF.md
# USB Root Port Companion Router

The router sits between the root-hub ports of a USB host and three controller interfaces: one high-speed controller that can reach every port, and two full/low-speed companion controllers whose ports are fixed by port parity. Ports 1, 3 and 5 belong to companion A. Ports 2 and 4 belong to companion B. Each port has one ownership bit. When the bit is set, the port is handed to the high-speed controller. When the bit is clear, the port goes to its fixed companion. The router passes line state and connect status from the port to its owner, and passes the owner's power request back to the port's power-enable output.

Each port runs a small state machine with four states. `PS_OFF` means the port is absent or held in reset. `PS_COMP` means the companion owns the port. `PS_HIGH` means the high-speed controller owns it. `PS_HAND` is a one-cycle gap during a change of owner.

The named transitions are:
- **enable**: `PS_OFF` goes straight to the requested owner.
- **claim**: `PS_COMP` goes to `PS_HAND` when the ownership bit rises.
- **release**: `PS_HIGH` goes to `PS_HAND` when the ownership bit falls.
- **settle**: `PS_HAND` goes to the requested owner.
- **disable**: any state goes to `PS_OFF` when the port lies above the configured count.

A configured count of enabled ports (2 to 5) marks the higher-numbered ports as absent. Per-port overcurrent inputs are active low. An overcurrent cuts power and raises a sticky flag that the owner clears.

Top module: `usb_rp_router`

## Requirements
- R1: Under reset every port is in `PS_OFF`. All connect, line-state, flag and power-enable outputs are 0.
- R2: With its ownership bit clear, port p (index p-1) is presented to a companion. Odd port numbers go to companion A, slot (p-1)/2. Even port numbers go to companion B, slot (p-1)/2. The port's connect bit and 2-bit line state (bits 2i+1:2i of the line-state buses) are passed through unchanged.
- R3: With its ownership bit set, port p is presented on bit p-1 of the high-speed buses.
- R4: Ports numbered above the configured count show no owner, no power and no flag, whatever their overcurrent input. A count below 2 acts as 2, and a count above 5 acts as 5. A port that becomes enabled again goes to its owner after one edge, with no handover gap.
- R5: If the ownership bit changes at clock edge k, the old owner sees a disconnect (connect 0, line state 00) from edge k onward. The new owner sees the port from edge k+1. Power is off between the two edges.
- R6: A controller that does not own a port sees connect 0, line state 00 and flag 0 for it. Its power request for that port has no effect.
- R7: A port's power enable equals its owner's power request while the overcurrent input is high. It is 0 in the same cycle the input is low.
- R8: An overcurrent seen at an edge while the port is owned sets the sticky flag of the owner from that edge on. The flag stays set after the overcurrent ends, until the owner pulses its clear bit. A clear bit from a non-owner is ignored.
- R9: If a clear bit and an overcurrent arrive in the same cycle, the flag stays set.
- R10: A handover or a disable clears the flag. This takes precedence over an overcurrent at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_port_count | input | 3 | Number of enabled ports |
| hs_owner | input | 5 | Per-port ownership bit, 1 = high-speed controller |
| port_conn | input | 5 | Per-port connect detect |
| port_ls | input | 10 | Per-port line state, 2 bits each |
| port_oc_n | input | 5 | Per-port overcurrent, active low |
| port_pwr_en | output | 5 | Per-port power enable |
| hs_pwr_req | input | 5 | High-speed controller power request |
| hs_occ_clr | input | 5 | High-speed controller flag clear |
| hs_conn | output | 5 | Connect status to high-speed controller |
| hs_ls | output | 10 | Line state to high-speed controller |
| hs_occ | output | 5 | Overcurrent flags to high-speed controller |
| ca_pwr_req | input | 3 | Companion A power request |
| ca_occ_clr | input | 3 | Companion A flag clear |
| ca_conn | output | 3 | Connect status to companion A |
| ca_ls | output | 6 | Line state to companion A |
| ca_occ | output | 3 | Overcurrent flags to companion A |
| cb_pwr_req | input | 2 | Companion B power request |
| cb_occ_clr | input | 2 | Companion B flag clear |
| cb_conn | output | 2 | Connect status to companion B |
| cb_ls | output | 4 | Line state to companion B |
| cb_occ | output | 2 | Overcurrent flags to companion B |

## Verification
The sticky overcurrent flag can see a set and a clear in the same cycle. It can also see a set and a handover in the same cycle. The bench provokes the first case by pulsing the companion's clear bit while holding the overcurrent low, and expects the flag to stay up. It provokes the second case by flipping the ownership bit in the same cycle the overcurrent begins. It then expects the flag to be 0 during the handover cycle, still 0 on the first cycle of the new owner, and set on the cycle after that, on the high-speed buses.

// File: rtl/usb_rp_pkg.sv
package usb_rp_pkg;
    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_COMP = 2'd1,
        PS_HAND = 2'd2,
        PS_HIGH = 2'd3
    } port_st_t;
endpackage

// File: rtl/usb_rp_count_dec.sv
module usb_rp_count_dec #(
    parameter int NPORT     = 5,
    parameter int MIN_PORTS = 2,
    parameter int CNT_W     = 3
) (
    input  logic [CNT_W-1:0] cfg_count,
    output logic [NPORT-1:0] en_mask
);
    int eff;

    // clamp the configured count into the legal window
    always_comb begin
        eff = int'(cfg_count);
        if (eff < MIN_PORTS) eff = MIN_PORTS;
        if (eff > NPORT)     eff = NPORT;
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_en
        assign en_mask[i] = (eff > i);
    end
endmodule

// File: rtl/usb_rp_port_fsm.sv
module usb_rp_port_fsm
    import usb_rp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enabled,
    input  logic want_high,
    input  logic oc_n,
    input  logic high_pwr_req,
    input  logic comp_pwr_req,
    input  logic high_clr,
    input  logic comp_clr,
    output logic own_high,
    output logic own_comp,
    output logic pwr_en,
    output logic oc_flag
);
    port_st_t st, st_nx;
    logic     owner_clr;
    logic     owned;

    // next-state selection
    always_comb begin
        st_nx = st;
        if (!enabled) begin
            st_nx = PS_OFF;
        end else begin
            unique case (st)
                PS_OFF:  st_nx = want_high ? PS_HIGH : PS_COMP;   // enable
                PS_COMP: st_nx = want_high ? PS_HAND : PS_COMP;   // claim
                PS_HIGH: st_nx = want_high ? PS_HIGH : PS_HAND;   // release
                PS_HAND: st_nx = want_high ? PS_HIGH : PS_COMP;   // settle
                default: st_nx = PS_OFF;
            endcase
        end
    end

    // state and sticky flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= PS_OFF;
            oc_flag <= 1'b0;
        end else begin
            st <= st_nx;
            if (st_nx == PS_HAND || st_nx == PS_OFF)
                oc_flag <= 1'b0;
            else if (owned && !oc_n)
                oc_flag <= 1'b1;
            else if (owner_clr)
                oc_flag <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        own_high  = 1'b0;
        own_comp  = 1'b0;
        pwr_en    = 1'b0;
        owner_clr = 1'b0;
        unique case (st)
            PS_HIGH: begin
                own_high  = 1'b1;
                pwr_en    = high_pwr_req & oc_n;
                owner_clr = high_clr;
            end
            PS_COMP: begin
                own_comp  = 1'b1;
                pwr_en    = comp_pwr_req & oc_n;
                owner_clr = comp_clr;
            end
            default: ;
        endcase
        owned = own_high | own_comp;
    end

    // R5: an owner change always passes through the gap state
    a_r5_enter_hand: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && ((st == PS_COMP && want_high) || (st == PS_HIGH && !want_high)))
        |=> (st == PS_HAND));
    a_r5_settle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_HAND && enabled && want_high) |=> (st == PS_HIGH));
    a_r5_settle_comp: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_HAND && enabled && !want_high) |=> (st == PS_COMP));
    // R9: an overcurrent at a steady owner always leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && !oc_n && st_nx == st) |=> oc_flag);
    // R8: the flag holds until the owner clears it
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag && !owner_clr && st_nx == st) |=> oc_flag);
    // R10: a handover or a disable empties the flag
    a_r10_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_nx == PS_HAND || st_nx == PS_OFF) |=> !oc_flag);
endmodule

// File: rtl/usb_rp_router.sv
module usb_rp_router #(
    parameter  int NPORT = 5,
    parameter  int CNT_W = 3,
    localparam int NA    = (NPORT + 1) / 2,
    localparam int NB    = NPORT / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cfg_port_count,
    input  logic [NPORT-1:0]   hs_owner,
    input  logic [NPORT-1:0]   port_conn,
    input  logic [2*NPORT-1:0] port_ls,
    input  logic [NPORT-1:0]   port_oc_n,
    output logic [NPORT-1:0]   port_pwr_en,
    input  logic [NPORT-1:0]   hs_pwr_req,
    input  logic [NPORT-1:0]   hs_occ_clr,
    output logic [NPORT-1:0]   hs_conn,
    output logic [2*NPORT-1:0] hs_ls,
    output logic [NPORT-1:0]   hs_occ,
    input  logic [NA-1:0]      ca_pwr_req,
    input  logic [NA-1:0]      ca_occ_clr,
    output logic [NA-1:0]      ca_conn,
    output logic [2*NA-1:0]    ca_ls,
    output logic [NA-1:0]      ca_occ,
    input  logic [NB-1:0]      cb_pwr_req,
    input  logic [NB-1:0]      cb_occ_clr,
    output logic [NB-1:0]      cb_conn,
    output logic [2*NB-1:0]    cb_ls,
    output logic [NB-1:0]      cb_occ
);
    logic [NPORT-1:0] en_mask;
    logic [NPORT-1:0] own_high, own_comp, oc_flag, comp_req, comp_clr;

    usb_rp_count_dec #(.NPORT(NPORT), .MIN_PORTS(2), .CNT_W(CNT_W)) u_cnt (
        .cfg_count (cfg_port_count),
        .en_mask   (en_mask)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        usb_rp_port_fsm u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .enabled      (en_mask[i]),
            .want_high    (hs_owner[i]),
            .oc_n         (port_oc_n[i]),
            .high_pwr_req (hs_pwr_req[i]),
            .comp_pwr_req (comp_req[i]),
            .high_clr     (hs_occ_clr[i]),
            .comp_clr     (comp_clr[i]),
            .own_high     (own_high[i]),
            .own_comp     (own_comp[i]),
            .pwr_en       (port_pwr_en[i]),
            .oc_flag      (oc_flag[i])
        );

        assign hs_conn[i]       = own_high[i] & port_conn[i];
        assign hs_ls[2*i +: 2]  = own_high[i] ? port_ls[2*i +: 2] : 2'b00;
        assign hs_occ[i]        = own_high[i] & oc_flag[i];

        // fixed companion by parity: even index to A, odd index to B
        if (i % 2 == 0) begin : g_ca
            assign comp_req[i]         = ca_pwr_req[i/2];
            assign comp_clr[i]         = ca_occ_clr[i/2];
            assign ca_conn[i/2]        = own_comp[i] & port_conn[i];
            assign ca_ls[2*(i/2) +: 2] = own_comp[i] ? port_ls[2*i +: 2] : 2'b00;
            assign ca_occ[i/2]         = own_comp[i] & oc_flag[i];
        end else begin : g_cb
            assign comp_req[i]         = cb_pwr_req[i/2];
            assign comp_clr[i]         = cb_occ_clr[i/2];
            assign cb_conn[i/2]        = own_comp[i] & port_conn[i];
            assign cb_ls[2*(i/2) +: 2] = own_comp[i] ? port_ls[2*i +: 2] : 2'b00;
            assign cb_occ[i/2]         = own_comp[i] & oc_flag[i];
        end

        // R7: overcurrent at the port removes its power
        a_r7_oc_cuts_power: assert property (@(posedge clk) disable iff (!rst_n)
            !port_oc_n[i] |-> !port_pwr_en[i]);
        // R4: a port above the count is dark one edge later
        a_r4_absent_dark: assert property (@(posedge clk) disable iff (!rst_n)
            !en_mask[i] |=> (!port_pwr_en[i] && !hs_occ[i] && !hs_conn[i]));
        // R6: never two owners at once
        a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({hs_conn[i], hs_occ[i], own_comp[i] & (port_conn[i] | oc_flag[i])}) ||
            !(own_comp[i] && (hs_conn[i] || hs_occ[i])));
    end
endmodule

// File: tb/sim_usb_rp_router.sv
module sim_usb_rp_router;
    localparam logic [1:0] N = 2'd0, H = 2'd1, C = 2'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cnt = 3'd5;
    logic [4:0] own = 5'b0, conn = 5'b10110, oc_n = 5'b11111;
    logic [9:0] ls = 10'b01_10_11_01_10;
    logic [4:0] hs_req = 5'h1F, hs_clr = 5'h0;
    logic [2:0] ca_req = 3'h7, ca_clr = 3'h0;
    logic [1:0] cb_req = 2'h3, cb_clr = 2'h0;
    logic [4:0] pwr, hs_conn, hs_occ;
    logic [9:0] hs_ls;
    logic [2:0] ca_conn, ca_occ;
    logic [5:0] ca_ls;
    logic [1:0] cb_conn, cb_occ;
    logic [3:0] cb_ls;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [9:0] owner;
        logic [4:0] pwr;
        logic [4:0] occ;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    usb_rp_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_port_count(cnt), .hs_owner(own),
        .port_conn(conn), .port_ls(ls), .port_oc_n(oc_n), .port_pwr_en(pwr),
        .hs_pwr_req(hs_req), .hs_occ_clr(hs_clr), .hs_conn(hs_conn),
        .hs_ls(hs_ls), .hs_occ(hs_occ),
        .ca_pwr_req(ca_req), .ca_occ_clr(ca_clr), .ca_conn(ca_conn),
        .ca_ls(ca_ls), .ca_occ(ca_occ),
        .cb_pwr_req(cb_req), .cb_occ_clr(cb_clr), .cb_conn(cb_conn),
        .cb_ls(cb_ls), .cb_occ(cb_occ)
    );

    // driver: queue the outputs expected after the next clock edge
    task automatic step(input logic [9:0] owner, input logic [4:0] p,
                        input logic [4:0] o, input string tag);
        exp_t e;
        e.owner = owner; e.pwr = p; e.occ = o; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    task automatic cmp(input logic [31:0] act, input logic [31:0] expv,
                       input string what, input string tag);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #4;
            if (sbq.size() > 0) begin
                exp_t e;
                logic [21:0] ea, aa;
                logic [21:0] eb, ab;
                e = sbq.pop_front();
                ea = '0; eb = '0;
                // ea: {hs_conn, ca_conn, cb_conn}, eb: {hs_ls, ca_ls, cb_ls}
                for (int i = 0; i < 5; i++) begin
                    logic [1:0] ow;
                    ow = e.owner[2*i +: 2];
                    if (ow == H) begin
                        ea[5+i] = conn[i];
                        eb[10+2*i +: 2] = ls[2*i +: 2];
                    end else if (ow == C && i % 2 == 0) begin
                        ea[2+i/2] = conn[i];
                        eb[4+2*(i/2) +: 2] = ls[2*i +: 2];
                    end else if (ow == C) begin
                        ea[i/2] = conn[i];
                        eb[2*(i/2) +: 2] = ls[2*i +: 2];
                    end
                end
                aa = {12'b0, hs_conn, ca_conn, cb_conn};
                ab = {2'b0, hs_ls, ca_ls, cb_ls};
                cmp(32'(aa), 32'(ea), "connect", e.tag);
                cmp(32'(ab), 32'(eb), "linestate", e.tag);
                cmp(32'(pwr), 32'(e.pwr), "power", e.tag);
                begin
                    logic [9:0] eo, ao;
                    eo = '0;
                    for (int i = 0; i < 5; i++) begin
                        if (e.owner[2*i +: 2] == H) eo[5+i] = e.occ[i];
                        else if (e.owner[2*i +: 2] == C && i % 2 == 0) eo[2+i/2] = e.occ[i];
                        else if (e.owner[2*i +: 2] == C) eo[i/2] = e.occ[i];
                    end
                    ao = {hs_occ, ca_occ, cb_occ};
                    cmp(32'(ao), 32'(eo), "ocflag", e.tag);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step({N,N,N,N,N}, 5'b00000, 5'b00000, "R1 reset");
        step({N,N,N,N,N}, 5'b00000, 5'b00000, "R1 reset hold");
        rst_n = 1'b1;
        step({C,C,C,C,C}, 5'b11111, 5'b00000, "R2 companions");
        own = 5'b00101;
        step({C,C,N,C,N}, 5'b11010, 5'b00000, "R5 handover gap");
        conn = 5'b01011; ls = 10'b11_00_10_01_11;
        step({C,C,H,C,H}, 5'b11111, 5'b00000, "R3 high-speed owns");
        hs_req = 5'b11110; ca_req = 3'b000;
        step({C,C,H,C,H}, 5'b01110, 5'b00000, "R6 R7 requests");
        hs_req = 5'h1F; ca_req = 3'h7; oc_n = 5'b11101;
        step({C,C,H,C,H}, 5'b11101, 5'b00010, "R7 R8 overcurrent");
        oc_n = 5'b11111; hs_clr = 5'b00010;
        step({C,C,H,C,H}, 5'b11111, 5'b00010, "R6 R8 foreign clear");
        hs_clr = 5'b0; oc_n = 5'b11101; cb_clr = 2'b01;
        step({C,C,H,C,H}, 5'b11101, 5'b00010, "R9 set wins");
        oc_n = 5'b11111;
        step({C,C,H,C,H}, 5'b11111, 5'b00000, "R8 owner clear");
        cb_clr = 2'b0; own = 5'b01101; oc_n = 5'b10111;
        step({C,N,H,C,H}, 5'b10111, 5'b00000, "R10 handover beats set");
        step({C,H,H,C,H}, 5'b10111, 5'b00000, "R5 new owner");
        step({C,H,H,C,H}, 5'b10111, 5'b01000, "R8 flag on new owner");
        oc_n = 5'b11111; own = 5'b00101;
        step({C,N,H,C,H}, 5'b10111, 5'b00000, "R10 release clears");
        step({C,C,H,C,H}, 5'b11111, 5'b00000, "R2 back to companion");
        cnt = 3'd3; oc_n = 5'b01111;
        step({N,N,H,C,H}, 5'b00111, 5'b00000, "R4 count three");
        step({N,N,H,C,H}, 5'b00111, 5'b00000, "R4 absent no flag");
        cnt = 3'd1;
        step({N,N,N,C,H}, 5'b00011, 5'b00000, "R4 count below two");
        cnt = 3'd7; oc_n = 5'b11111;
        step({C,C,H,C,H}, 5'b11111, 5'b00000, "R4 count above five");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule